// File: doc/BRIEF.md
# I2C Master Register and Interrupt File

This block is the software-facing register file of a simple I2C master. A plain 32-bit register bus writes and reads word-addressed registers. The block decodes each access, holds the configuration, and drives strobes and static settings into a byte engine that lies outside it. It latches the engine's event pulses into sticky interrupt flags and presents a single masked interrupt line.

The control word carries the direction, master, 7-bit addressing, acknowledge, hold and bus-monitor bits, plus a two-field clock divisor. It also carries a FIFO flush request that never stays set. The data register is a port, not storage: writes push a byte toward the transmit FIFO and reads pop a byte from the receive FIFO. Interrupt flags are cleared by writing ones. Masking goes through separate set and clear registers, so no read-modify-write is needed.

Word offsets: 0 control, 1 status, 2 target address, 3 data port, 4 interrupt flags, 5 interrupt mask (read), 6 interrupt enable (write), 7 interrupt disable (write), 8 transfer size.

Top module: `i2cr_regfile`

## Requirements
- R1: After reset, control, target address, transfer size and interrupt flags read 0. The mask reads 0x2FF (all implemented sources masked) and `irq` is 0.
- R2: Control bits 0..5 (receive direction, master, 7-bit addressing, ack enable, hold, bus monitor), bits 13:8 (divisor B) and bits 15:14 (divisor A) store the written value, read back, and drive the matching outputs. Bits 6, 7 and 31:16 read 0.
- R3: Writing control with bit 6 set raises `fifo_flush` for exactly one cycle, the cycle after the write.
- R4: Status reads engine inputs `eng_status[0..3]` (rx valid, tx valid, rx overflow, bus active) at bits 5..8. Every other bit reads 0.
- R5: An event pulse on `evt_pulse[i]` sets flag i, which stays set. Implemented flags are bits 0..7 and 9. Bit 8 never sets.
- R6: Writing the flag register clears each flag whose data bit is 1 and leaves flags under a 0 bit unchanged. Writing 0xFF clears bits 0..7.
- R7: An event pulse in the same cycle as a clearing write on that bit leaves the flag set.
- R8: A write to offset 7 sets mask bits under ones, and a write to offset 6 clears them. `irq` is the OR of the flags whose mask bit is 0.
- R9: A data-port write raises `tx_push` in that cycle with `tx_byte` equal to write data bits 7:0. A data-port read raises `rx_pop` in that cycle and returns `rx_byte` in bits 7:0.
- R10: Target address keeps 10 bits and transfer size keeps 8 bits. A size write pulses `size_load` in the write cycle. Each `size_dec` pulse lowers the size by one, and the size never goes below 0.
- R11: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on offset |
| eng_status | input | 4 | Engine status levels |
| evt_pulse | input | 10 | Engine event pulses |
| rx_byte | input | 8 | Head byte of receive FIFO |
| size_dec | input | 1 | Engine byte-done pulse |
| ctl_dir_rx | output | 1 | Master receive direction |
| ctl_master | output | 1 | Master mode |
| ctl_addr7 | output | 1 | 7-bit addressing |
| ctl_ack_en | output | 1 | Acknowledge enable |
| ctl_hold | output | 1 | Hold bus after transfer |
| ctl_slv_mon | output | 1 | Bus monitor mode |
| div_a | output | 2 | Clock divisor A |
| div_b | output | 6 | Clock divisor B |
| fifo_flush | output | 1 | One-cycle FIFO flush |
| target_addr | output | 10 | Target device address |
| xfer_size | output | 8 | Transfer size count |
| size_load | output | 1 | Size write strobe |
| tx_push | output | 1 | Transmit FIFO push |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Receive FIFO pop |
| irq | output | 1 | Masked interrupt |

## Verification
The store-and-read-back path is tried with all ones, with a mixed control pattern and with values wider than the field. These tell correct field packing apart from bit shifts and from missing truncation. The flag file is driven by a lone pulse, a pulse on the unimplemented bit, a burst on every source, a partial clear, an all-zero write and an event that collides with a clear. These separate sticky, write-one-to-clear behaviour from plain write semantics and from a wrong collision priority. Mask set and clear writes are combined with pending flags to show that `irq` follows the mask and not only the flags.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int BUS_W  = 32;
  localparam int REG_AW = 4;
  localparam int STAT_W = 4;
  localparam int STAT_LSB = 5;
  localparam int BYTE_W = 8;

  // control word bit positions
  localparam int CB_DIR   = 0;
  localparam int CB_MST   = 1;
  localparam int CB_A7    = 2;
  localparam int CB_ACK   = 3;
  localparam int CB_HOLD  = 4;
  localparam int CB_MON   = 5;
  localparam int CB_FLUSH = 6;
  localparam int DIVB_LSB = 8;
  localparam int DIVB_W   = 6;
  localparam int DIVA_LSB = 14;
  localparam int DIVA_W   = 2;

  typedef enum logic [REG_AW-1:0] {
    OFS_CTRL  = 4'd0,
    OFS_STAT  = 4'd1,
    OFS_TADDR = 4'd2,
    OFS_DATA  = 4'd3,
    OFS_ISR   = 4'd4,
    OFS_IMASK = 4'd5,
    OFS_IEN   = 4'd6,
    OFS_IDIS  = 4'd7,
    OFS_SIZE  = 4'd8
  } reg_ofs_e;

  typedef struct packed {
    logic [DIVA_W-1:0] div_a;
    logic [DIVB_W-1:0] div_b;
    logic slv_mon;
    logic hold;
    logic ack_en;
    logic addr7;
    logic master;
    logic dir_rx;
  } ctl_t;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_taddr;
    logic wr_data;
    logic wr_isr;
    logic wr_ien;
    logic wr_idis;
    logic wr_size;
    logic rd_data;
  } strobe_t;
endpackage

// File: rtl/i2cr_decode.sv
module i2cr_decode
  import i2cr_pkg::*;
(
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL:  stb.wr_ctrl  = 1'b1;
        OFS_TADDR: stb.wr_taddr = 1'b1;
        OFS_DATA:  stb.wr_data  = 1'b1;
        OFS_ISR:   stb.wr_isr   = 1'b1;
        OFS_IEN:   stb.wr_ien   = 1'b1;
        OFS_IDIS:  stb.wr_idis  = 1'b1;
        OFS_SIZE:  stb.wr_size  = 1'b1;
        default:   ;
      endcase
    end
    if (bus_rd && bus_addr == OFS_DATA) stb.rd_data = 1'b1;
  end
endmodule

// File: rtl/i2cr_ctrl_regs.sv
module i2cr_ctrl_regs
  import i2cr_pkg::*;
#(
  parameter int TADDR_W = 10,
  parameter int SIZE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               size_dec,
  output ctl_t               ctl,
  output logic               flush,
  output logic [TADDR_W-1:0] taddr,
  output logic [SIZE_W-1:0]  size
);
  ctl_t               ctl_q, ctl_d;
  logic               flush_q, flush_d;
  logic [TADDR_W-1:0] taddr_q, taddr_d;
  logic [SIZE_W-1:0]  size_q, size_d;
  logic               ctl_en, taddr_en, size_en;

  // clock enables
  assign ctl_en   = stb.wr_ctrl;
  assign taddr_en = stb.wr_taddr;
  assign size_en  = stb.wr_size | (size_dec & (size_q != '0));

  always_comb begin
    ctl_d         = ctl_q;
    ctl_d.dir_rx  = wdata[CB_DIR];
    ctl_d.master  = wdata[CB_MST];
    ctl_d.addr7   = wdata[CB_A7];
    ctl_d.ack_en  = wdata[CB_ACK];
    ctl_d.hold    = wdata[CB_HOLD];
    ctl_d.slv_mon = wdata[CB_MON];
    ctl_d.div_b   = wdata[DIVB_LSB +: DIVB_W];
    ctl_d.div_a   = wdata[DIVA_LSB +: DIVA_W];
    flush_d       = stb.wr_ctrl & wdata[CB_FLUSH];
    taddr_d       = wdata[TADDR_W-1:0];
    if (stb.wr_size) size_d = wdata[SIZE_W-1:0];
    else             size_d = size_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      flush_q <= 1'b0;
      taddr_q <= '0;
      size_q  <= '0;
    end else begin
      flush_q <= flush_d;
      if (ctl_en)   ctl_q   <= ctl_d;
      if (taddr_en) taddr_q <= taddr_d;
      if (size_en)  size_q  <= size_d;
    end
  end

  assign ctl   = ctl_q;
  assign flush = flush_q;
  assign taddr = taddr_q;
  assign size  = size_q;

  // R3
  flush_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wr_ctrl && wdata[CB_FLUSH]) |=> flush);
  // R3
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !(stb.wr_ctrl && wdata[CB_FLUSH])) |=> !flush);
  // R10
  size_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size == '0 && !stb.wr_size) |=> size == '0);
endmodule

// File: rtl/i2cr_irq_file.sv
module i2cr_irq_file #(
  parameter int                   NUM_EVT = 10,
  parameter logic [NUM_EVT-1:0]   IMPL    = 10'h2FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               wr_isr,
  input  logic               wr_ien,
  input  logic               wr_idis,
  input  logic [NUM_EVT-1:0] wdata,
  output logic [NUM_EVT-1:0] flags,
  output logic [NUM_EVT-1:0] mask,
  output logic               irq
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_src
    if (IMPL[i]) begin : g_impl
      logic flag_q, flag_d, mask_q, mask_d, flag_en, mask_en;

      assign flag_en = evt[i] | (wr_isr & wdata[i]);
      assign mask_en = (wr_ien | wr_idis) & wdata[i];

      always_comb begin
        flag_d = evt[i];
        mask_d = wr_idis;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= 1'b0;
          mask_q <= 1'b1;
        end else begin
          if (flag_en) flag_q <= flag_d;
          if (mask_en) mask_q <= mask_d;
        end
      end

      assign flags[i] = flag_q;
      assign mask[i]  = mask_q;

      // R7
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flags[i]);
      // R6
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_isr && wdata[i] && !evt[i]) |=> !flags[i]);
      // R5
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !(wr_isr && wdata[i])) |=> flags[i]);
    end else begin : g_none
      assign flags[i] = 1'b0;
      assign mask[i]  = 1'b0;
    end
  end

  assign irq = |(flags & ~mask);
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile
  import i2cr_pkg::*;
#(
  parameter int                 TADDR_W  = 10,
  parameter int                 SIZE_W   = 8,
  parameter int                 NUM_EVT  = 10,
  parameter logic [NUM_EVT-1:0] EVT_IMPL = 10'h2FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [STAT_W-1:0]  eng_status,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic               size_dec,
  output logic               ctl_dir_rx,
  output logic               ctl_master,
  output logic               ctl_addr7,
  output logic               ctl_ack_en,
  output logic               ctl_hold,
  output logic               ctl_slv_mon,
  output logic [DIVA_W-1:0]  div_a,
  output logic [DIVB_W-1:0]  div_b,
  output logic               fifo_flush,
  output logic [TADDR_W-1:0] target_addr,
  output logic [SIZE_W-1:0]  xfer_size,
  output logic               size_load,
  output logic               tx_push,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic               rx_pop,
  output logic               irq
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  strobe_t            stb;
  ctl_t               ctl;
  logic [NUM_EVT-1:0] flags, mask;

  i2cr_decode u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .stb      (stb)
  );

  i2cr_ctrl_regs #(.TADDR_W(TADDR_W), .SIZE_W(SIZE_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_q),
    .stb      (stb),
    .wdata    (bus_wdata),
    .size_dec (size_dec),
    .ctl      (ctl),
    .flush    (fifo_flush),
    .taddr    (target_addr),
    .size     (xfer_size)
  );

  i2cr_irq_file #(.NUM_EVT(NUM_EVT), .IMPL(EVT_IMPL)) u_irq (
    .clk     (clk),
    .rst_n   (rst_q),
    .evt     (evt_pulse),
    .wr_isr  (stb.wr_isr),
    .wr_ien  (stb.wr_ien),
    .wr_idis (stb.wr_idis),
    .wdata   (bus_wdata[NUM_EVT-1:0]),
    .flags   (flags),
    .mask    (mask),
    .irq     (irq)
  );

  assign ctl_dir_rx  = ctl.dir_rx;
  assign ctl_master  = ctl.master;
  assign ctl_addr7   = ctl.addr7;
  assign ctl_ack_en  = ctl.ack_en;
  assign ctl_hold    = ctl.hold;
  assign ctl_slv_mon = ctl.slv_mon;
  assign div_a       = ctl.div_a;
  assign div_b       = ctl.div_b;
  assign size_load   = stb.wr_size;
  assign tx_push     = stb.wr_data;
  assign tx_byte     = bus_wdata[BYTE_W-1:0];
  assign rx_pop      = stb.rd_data;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:  bus_rdata = BUS_W'({ctl.div_a, ctl.div_b, 2'b00, ctl.slv_mon,
                                     ctl.hold, ctl.ack_en, ctl.addr7,
                                     ctl.master, ctl.dir_rx});
      OFS_STAT:  bus_rdata[STAT_LSB +: STAT_W] = eng_status;
      OFS_TADDR: bus_rdata = BUS_W'(target_addr);
      OFS_DATA:  bus_rdata = BUS_W'(rx_byte);
      OFS_ISR:   bus_rdata = BUS_W'(flags);
      OFS_IMASK: bus_rdata = BUS_W'(mask);
      OFS_SIZE:  bus_rdata = BUS_W'(xfer_size);
      default:   bus_rdata = '0;
    endcase
  end

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mask == EVT_IMPL) |-> !irq);
  // R8
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((flags & ~mask) != '0) |-> irq);
endmodule

// File: tb/i2cr_regfile_test.sv
`timescale 1ns/100ps
module i2cr_regfile_test;
  logic        clk, rst_n, bus_wr, bus_rd, size_dec;
  logic [3:0]  bus_addr, eng_status;
  logic [31:0] bus_wdata, bus_rdata;
  logic [9:0]  evt_pulse, target_addr;
  logic [7:0]  rx_byte, xfer_size, tx_byte;
  logic        ctl_dir_rx, ctl_master, ctl_addr7, ctl_ack_en, ctl_hold, ctl_slv_mon;
  logic [1:0]  div_a;
  logic [5:0]  div_b;
  logic        fifo_flush, size_load, tx_push, rx_pop, irq;
  int checks = 0, failures = 0;
  logic seen_load, seen_push, seen_pop;
  logic [7:0] seen_byte;
  logic [31:0] rd;

  i2cr_regfile uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    seen_load = size_load; seen_push = tx_push; seen_byte = tx_byte;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata; seen_pop = rx_pop;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  // write offset, write data, read offset, expected read, requirement number
  localparam int NV = 9;
  localparam logic [3:0]  V_WA [NV] = '{4'd0, 4'd0, 4'd2, 4'd8, 4'd6, 4'd7, 4'd6, 4'd15, 4'd6};
  localparam logic [31:0] V_WD [NV] = '{32'h0000_FFFF, 32'h0000_A52B, 32'hFFFF_F3A5, 32'h0000_01FF,
                                        32'hFFFF_FFFF, 32'h0000_0201, 32'h0000_0001, 32'hFFFF_FFFF,
                                        32'h0000_0200};
  localparam logic [3:0]  V_RA [NV] = '{4'd0, 4'd0, 4'd2, 4'd8, 4'd5, 4'd5, 4'd5, 4'd15, 4'd5};
  localparam logic [31:0] V_EX [NV] = '{32'h0000_FF3F, 32'h0000_A52B, 32'h0000_03A5, 32'h0000_00FF,
                                        32'h0, 32'h0000_0201, 32'h0000_0200, 32'h0, 32'h0};
  // rows: R2, R2, R10, R10, R8, R8, R8, R11, R8
  localparam int V_RQ [NV] = '{2, 2, 10, 10, 8, 8, 8, 11, 8};

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    eng_status = 0; evt_pulse = 0; rx_byte = 0; size_dec = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdreg(4'd0, rd); chk("R1 ctrl", rd, 0);
    rdreg(4'd4, rd); chk("R1 flags", rd, 0);
    rdreg(4'd5, rd); chk("R1 mask", rd, 32'h2FF);
    rdreg(4'd8, rd); chk("R1 size", rd, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      wr(V_WA[k], V_WD[k]);
      rdreg(V_RA[k], rd);
      checks++;
      if (rd !== V_EX[k]) begin
        failures++;
        $display("FAIL R%0d row %0d actual=0x%0h expected=0x%0h", V_RQ[k], k, rd, V_EX[k]);
      end
    end

    // R2 outputs after 0xA52B; R11 unmapped write left control intact
    chk("R2 low bits", {26'b0, ctl_slv_mon, ctl_hold, ctl_ack_en, ctl_addr7, ctl_master, ctl_dir_rx}, 32'h2B);
    chk("R2 div_b", {26'b0, div_b}, 32'h25);
    chk("R2 div_a", {30'b0, div_a}, 32'h2);
    rdreg(4'd0, rd); chk("R11 ctrl kept", rd, 32'hA52B);

    // R3 flush pulse
    chk("R3 idle", {31'b0, fifo_flush}, 0);
    wr(4'd0, 32'h0000_A56B);
    chk("R3 pulse", {31'b0, fifo_flush}, 1);
    @(negedge clk);
    chk("R3 single", {31'b0, fifo_flush}, 0);
    rdreg(4'd0, rd); chk("R3 reads 0", rd, 32'hA52B);

    // R4 status
    eng_status = 4'b1010;
    rdreg(4'd1, rd); chk("R4 status a", rd, 32'h140);
    eng_status = 4'b0101;
    rdreg(4'd1, rd); chk("R4 status b", rd, 32'h0A0);

    // R5 sticky flags
    pulse(10'h001);
    repeat (3) @(negedge clk);
    rdreg(4'd4, rd); chk("R5 sticky", rd, 32'h1);
    pulse(10'h100);
    rdreg(4'd4, rd); chk("R5 bit8 absent", rd, 32'h1);
    pulse(10'h200);
    rdreg(4'd4, rd); chk("R5 bit9", rd, 32'h201);

    // R6 write-one-to-clear
    wr(4'd4, 32'h0000_0001);
    rdreg(4'd4, rd); chk("R6 clear one", rd, 32'h200);
    wr(4'd4, 32'h0);
    rdreg(4'd4, rd); chk("R6 zero write", rd, 32'h200);
    pulse(10'h3FF);
    rdreg(4'd4, rd); chk("R6 all set", rd, 32'h2FF);
    wr(4'd4, 32'hFF);
    rdreg(4'd4, rd); chk("R6 clear low byte", rd, 32'h200);

    // R7 collision
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h200; evt_pulse = 10'h200;
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = '0;
    rdreg(4'd4, rd); chk("R7 event wins", rd, 32'h200);

    // R8 irq versus mask (mask is 0 here)
    #1 chk("R8 irq pending", {31'b0, irq}, 1);
    wr(4'd7, 32'h200);
    #1 chk("R8 irq masked", {31'b0, irq}, 0);
    wr(4'd6, 32'h200);
    #1 chk("R8 irq unmasked", {31'b0, irq}, 1);
    wr(4'd4, 32'h3FF);
    #1 chk("R8 irq cleared", {31'b0, irq}, 0);

    // R9 data port
    wr(4'd3, 32'h1234_56C3);
    chk("R9 push", {31'b0, seen_push}, 1);
    chk("R9 byte", {24'b0, seen_byte}, 32'hC3);
    rx_byte = 8'h5A;
    rdreg(4'd3, rd);
    chk("R9 pop", {31'b0, seen_pop}, 1);
    chk("R9 rx data", rd, 32'h5A);

    // R10 size load and floor
    wr(4'd8, 32'h3);
    chk("R10 load", {31'b0, seen_load}, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); size_dec = 1'b1;
      @(negedge clk); size_dec = 1'b0;
    end
    chk("R10 floor", {24'b0, xfer_size}, 0);
    wr(4'd2, 32'h0);
    chk("R10 no load", {31'b0, seen_load}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule